// File: doc/BRIEF.md
# Linear CCD Clock Sequencer

This block derives every digital drive waveform of a two-phase linear CCD image sensor from a fast system clock. Each line opens with a read gate pulse. During that pulse the first transfer phase is held high, with a programmable margin before the gate rises and after it falls. The line then shifts out pixels. Each pixel period carries a complementary pair of transfer clocks, a pixel reset pulse and an optional sample-and-hold pulse. Both pulses sit at programmable sub-pixel offsets from the pixel's opening transfer edge.

Every width and offset is a count of system-clock cycles taken from configuration inputs. A combinational check flags any set of values that does not fit inside one pixel period, and no line starts while that flag is raised. The line length has a hardware floor, set by a parameter that defaults to 2750 pixels. Lines follow one another without a gap in free-running mode. In single-line mode one line runs for each start request. For a downstream converter, the block marks the first pixel of every line and gives a one-cycle valid strobe a programmable delay after each reset pulse.

All drive outputs come from registers and share the same one-cycle latency, so they stay aligned with one another.

Top module: `ccd_clock_seq`

## Requirements
- R1: `xfer_p2` is always the inverse of `xfer_p1`. Within each pixel of P = `cfg_pix_period` cycles, `xfer_p1` is low for the first floor(P/2) cycles and high for the remaining P - floor(P/2) cycles. A pixel starts at the falling edge of `xfer_p1`.
- R2: Every line begins with `read_gate` high for exactly `cfg_gate_width` cycles. `xfer_p1` is high throughout that pulse, and no pixel pulse, strobe or line mark occurs during it.
- R3: `read_gate` rises `cfg_gate_setup` cycles after the last pixel of the previous line ends. `xfer_p1` falls exactly `cfg_gate_hold` cycles after `read_gate` falls.
- R4: A line holds max(`cfg_line_len`, MIN_LINE_PIX) pixels. MIN_LINE_PIX defaults to 2750.
- R5: `pix_reset` is high for exactly `cfg_rs_width` cycles once per pixel. It starts `cfg_rs_delay` cycles after the pixel starts.
- R6: With `cfg_sh_en`=1, `samp_hold` is high for `cfg_sh_width` cycles once per pixel, starting `cfg_sh_delay` cycles after the pixel starts. With `cfg_sh_en`=0 it stays low.
- R7: `pix_valid` is a one-cycle pulse once per pixel. It comes `cfg_valid_delay` cycles after `pix_reset` falls, which is cycle offset `cfg_rs_delay`+`cfg_rs_width`+`cfg_valid_delay` of the pixel.
- R8: `line_start` is a one-cycle pulse in the first cycle of the first pixel of every line.
- R9: `cfg_err` is 1 when any of these holds:
  - P < 2;
  - any width or gate count is zero (the sample-and-hold width only when enabled);
  - `cfg_rs_delay`+`cfg_rs_width`+`cfg_valid_delay` >= P;
  - with sample-and-hold enabled, `cfg_sh_delay` < `cfg_rs_delay`+`cfg_rs_width`, or `cfg_sh_delay`+`cfg_sh_width` > P.

  While `cfg_err` is 1, no new line starts.
- R10: With `free_run`=1, the next line follows with no gap. With `free_run`=0, one line runs per `start` pulse seen while idle, and a `start` during a line is ignored.
- R11: After reset and while idle, `xfer_p1`=1, `xfer_p2`=0, and every other drive output and strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one line (single-line mode) |
| free_run | input | 1 | Run lines back to back |
| cfg_pix_period | input | CNT_W | System clocks per pixel |
| cfg_rs_delay | input | CNT_W | Reset pulse offset from pixel start |
| cfg_rs_width | input | CNT_W | Reset pulse width |
| cfg_sh_en | input | 1 | Enable sample-and-hold pulse |
| cfg_sh_delay | input | CNT_W | Sample-and-hold offset from pixel start |
| cfg_sh_width | input | CNT_W | Sample-and-hold width |
| cfg_valid_delay | input | CNT_W | Valid strobe delay after reset pulse ends |
| cfg_gate_setup | input | CNT_W | Cycles from line end to read gate rise |
| cfg_gate_width | input | CNT_W | Read gate width |
| cfg_gate_hold | input | CNT_W | Cycles from read gate fall to first pixel |
| cfg_line_len | input | LINE_W | Requested pixels per line |
| xfer_p1 | output | 1 | Transfer clock, phase 1 |
| xfer_p2 | output | 1 | Transfer clock, phase 2 |
| read_gate | output | 1 | Read gate pulse |
| pix_reset | output | 1 | Per-pixel reset pulse |
| samp_hold | output | 1 | Per-pixel sample-and-hold pulse |
| pix_valid | output | 1 | Converter sample strobe |
| line_start | output | 1 | First pixel of a line |
| cfg_err | output | 1 | Configuration does not fit |

## Verification
The bench sweeps pixel periods 4 to 9, both sample-and-hold settings, both line modes, and line lengths on both sides of a reduced floor. It compares every output every cycle against a waveform computed from the configuration. Odd pixel periods catch a transfer clock split with the wrong rounding, which would shift every later pulse by a cycle. A line length below the floor catches a design that skips the clamp: its lines would be short and the second gate would come early. It also drops free-run in the middle of a line and sends a start during a line, which catch an extra or missing line. Invalid configurations must raise the error flag and must never open a gate.

// File: rtl/ccd_seq_pkg.sv
// Shared types for the linear CCD clock sequencer.
package ccd_seq_pkg;
    // Line phases: idle, gate setup, gate high, gate hold, pixel shifting.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_GATE  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_PIX   = 3'd4
    } seq_state_t;
endpackage

// File: rtl/ccd_cfg_check.sv
// Configuration fit check. Flags any width/offset set that cannot be placed
// inside one pixel period. Purely combinational; assumes inputs are quasi-static.
module ccd_cfg_check #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cfg_pix_period,
    input  logic [CNT_W-1:0] cfg_rs_delay,
    input  logic [CNT_W-1:0] cfg_rs_width,
    input  logic             cfg_sh_en,
    input  logic [CNT_W-1:0] cfg_sh_delay,
    input  logic [CNT_W-1:0] cfg_sh_width,
    input  logic [CNT_W-1:0] cfg_valid_delay,
    input  logic [CNT_W-1:0] cfg_gate_setup,
    input  logic [CNT_W-1:0] cfg_gate_width,
    input  logic [CNT_W-1:0] cfg_gate_hold,
    output logic             cfg_err
);
    localparam int SUM_W = CNT_W + 2;

    logic [SUM_W-1:0] period_w, rs_end_w, valid_w, sh_end_w, sh_dly_w;

    // Widen sums so no overflow hides a misfit.
    always_comb begin
        period_w = SUM_W'(cfg_pix_period);
        rs_end_w = SUM_W'(cfg_rs_delay) + SUM_W'(cfg_rs_width);
        valid_w  = rs_end_w + SUM_W'(cfg_valid_delay);
        sh_dly_w = SUM_W'(cfg_sh_delay);
        sh_end_w = sh_dly_w + SUM_W'(cfg_sh_width);
    end

    // Combine every fit rule into one flag.
    always_comb begin
        cfg_err = (period_w < SUM_W'(2))
               || (cfg_rs_width == '0)
               || (cfg_gate_setup == '0)
               || (cfg_gate_width == '0)
               || (cfg_gate_hold == '0)
               || (valid_w >= period_w)
               || (cfg_sh_en && ((cfg_sh_width == '0)
                                 || (sh_dly_w < rs_end_w)
                                 || (sh_end_w > period_w)));
    end
endmodule

// File: rtl/ccd_line_fsm.sv
// Line sequencer. Walks setup, gate, hold and pixel phases with one phase
// counter and a pixel index. Assumes configuration changes only while idle.
module ccd_line_fsm
    import ccd_seq_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int LINE_W       = 12,
    parameter int MIN_LINE_PIX = 2750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              free_run,
    input  logic              cfg_err,
    input  logic [CNT_W-1:0]  cfg_pix_period,
    input  logic [CNT_W-1:0]  cfg_gate_setup,
    input  logic [CNT_W-1:0]  cfg_gate_width,
    input  logic [CNT_W-1:0]  cfg_gate_hold,
    input  logic [LINE_W-1:0] cfg_line_len,
    output seq_state_t        state,
    output logic [CNT_W-1:0]  sub_cnt,
    output logic [LINE_W-1:0] pix_idx
);
    localparam logic [LINE_W-1:0] MIN_LEN = LINE_W'(MIN_LINE_PIX);

    logic [CNT_W-1:0]  limit;
    logic [LINE_W-1:0] eff_len;
    logic              last_tick, last_pix;

    // Pick the length of the current phase and clamp the line length.
    always_comb begin
        case (state)
            ST_SETUP: limit = cfg_gate_setup;
            ST_GATE:  limit = cfg_gate_width;
            ST_HOLD:  limit = cfg_gate_hold;
            default:  limit = cfg_pix_period;
        endcase
        eff_len   = (cfg_line_len < MIN_LEN) ? MIN_LEN : cfg_line_len;
        last_tick = (sub_cnt == limit - CNT_W'(1));
        last_pix  = (pix_idx == eff_len - LINE_W'(1));
    end

    // Advance phase counter, pixel index and line phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sub_cnt <= '0;
            pix_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    sub_cnt <= '0;
                    pix_idx <= '0;
                    if (!cfg_err && (start || free_run)) state <= ST_SETUP;
                end
                ST_SETUP, ST_GATE, ST_HOLD: begin
                    if (last_tick) begin
                        sub_cnt <= '0;
                        pix_idx <= '0;
                        state   <= (state == ST_SETUP) ? ST_GATE :
                                   (state == ST_GATE)  ? ST_HOLD : ST_PIX;
                    end else begin
                        sub_cnt <= sub_cnt + CNT_W'(1);
                    end
                end
                default: begin
                    if (last_tick) begin
                        sub_cnt <= '0;
                        if (last_pix) begin
                            pix_idx <= '0;
                            state   <= (free_run && !cfg_err) ? ST_SETUP : ST_IDLE;
                        end else begin
                            pix_idx <= pix_idx + LINE_W'(1);
                        end
                    end else begin
                        sub_cnt <= sub_cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ccd_wave_gen.sv
// Waveform decoder. Turns line phase and sub-pixel position into the drive
// outputs, all registered so they share one cycle of latency.
module ccd_wave_gen
    import ccd_seq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic [CNT_W-1:0]  sub_cnt,
    input  logic [LINE_W-1:0] pix_idx,
    input  logic [CNT_W-1:0]  cfg_pix_period,
    input  logic [CNT_W-1:0]  cfg_rs_delay,
    input  logic [CNT_W-1:0]  cfg_rs_width,
    input  logic              cfg_sh_en,
    input  logic [CNT_W-1:0]  cfg_sh_delay,
    input  logic [CNT_W-1:0]  cfg_sh_width,
    input  logic [CNT_W-1:0]  cfg_valid_delay,
    output logic              xfer_p1,
    output logic              xfer_p2,
    output logic              read_gate,
    output logic              pix_reset,
    output logic              samp_hold,
    output logic              pix_valid,
    output logic              line_start
);
    localparam int SUM_W = CNT_W + 2;

    logic             in_pix, p1_n, rs_n, sh_n, pv_n, ls_n;
    logic [SUM_W-1:0] sub_w, rs_end_w, sh_end_w;

    // Decode next-cycle levels from the sub-pixel position.
    always_comb begin
        in_pix   = (state == ST_PIX);
        sub_w    = SUM_W'(sub_cnt);
        rs_end_w = SUM_W'(cfg_rs_delay) + SUM_W'(cfg_rs_width);
        sh_end_w = SUM_W'(cfg_sh_delay) + SUM_W'(cfg_sh_width);
        p1_n     = !(in_pix && (sub_cnt < (cfg_pix_period >> 1)));
        rs_n     = in_pix && (sub_w >= SUM_W'(cfg_rs_delay)) && (sub_w < rs_end_w);
        sh_n     = in_pix && cfg_sh_en && (sub_w >= SUM_W'(cfg_sh_delay))
                   && (sub_w < sh_end_w);
        pv_n     = in_pix && (sub_w == rs_end_w + SUM_W'(cfg_valid_delay));
        ls_n     = in_pix && (pix_idx == '0) && (sub_cnt == '0);
    end

    // Register all drive outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_p1    <= 1'b1;
            xfer_p2    <= 1'b0;
            read_gate  <= 1'b0;
            pix_reset  <= 1'b0;
            samp_hold  <= 1'b0;
            pix_valid  <= 1'b0;
            line_start <= 1'b0;
        end else begin
            xfer_p1    <= p1_n;
            xfer_p2    <= !p1_n;
            read_gate  <= (state == ST_GATE);
            pix_reset  <= rs_n;
            samp_hold  <= sh_n;
            pix_valid  <= pv_n;
            line_start <= ls_n;
        end
    end
endmodule

// File: rtl/ccd_clock_seq.sv
// Top of the linear CCD clock sequencer: configuration check, line
// sequencer and waveform decoder. Assumes configuration is held while a line runs.
module ccd_clock_seq
    import ccd_seq_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int LINE_W       = 12,
    parameter int MIN_LINE_PIX = 2750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              free_run,
    input  logic [CNT_W-1:0]  cfg_pix_period,
    input  logic [CNT_W-1:0]  cfg_rs_delay,
    input  logic [CNT_W-1:0]  cfg_rs_width,
    input  logic              cfg_sh_en,
    input  logic [CNT_W-1:0]  cfg_sh_delay,
    input  logic [CNT_W-1:0]  cfg_sh_width,
    input  logic [CNT_W-1:0]  cfg_valid_delay,
    input  logic [CNT_W-1:0]  cfg_gate_setup,
    input  logic [CNT_W-1:0]  cfg_gate_width,
    input  logic [CNT_W-1:0]  cfg_gate_hold,
    input  logic [LINE_W-1:0] cfg_line_len,
    output logic              xfer_p1,
    output logic              xfer_p2,
    output logic              read_gate,
    output logic              pix_reset,
    output logic              samp_hold,
    output logic              pix_valid,
    output logic              line_start,
    output logic              cfg_err
);
    seq_state_t        state;
    logic [CNT_W-1:0]  sub_cnt;
    logic [LINE_W-1:0] pix_idx;

    ccd_cfg_check #(.CNT_W(CNT_W)) u_check (
        .cfg_pix_period (cfg_pix_period),
        .cfg_rs_delay   (cfg_rs_delay),
        .cfg_rs_width   (cfg_rs_width),
        .cfg_sh_en      (cfg_sh_en),
        .cfg_sh_delay   (cfg_sh_delay),
        .cfg_sh_width   (cfg_sh_width),
        .cfg_valid_delay(cfg_valid_delay),
        .cfg_gate_setup (cfg_gate_setup),
        .cfg_gate_width (cfg_gate_width),
        .cfg_gate_hold  (cfg_gate_hold),
        .cfg_err        (cfg_err)
    );

    ccd_line_fsm #(.CNT_W(CNT_W), .LINE_W(LINE_W), .MIN_LINE_PIX(MIN_LINE_PIX)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .free_run      (free_run),
        .cfg_err       (cfg_err),
        .cfg_pix_period(cfg_pix_period),
        .cfg_gate_setup(cfg_gate_setup),
        .cfg_gate_width(cfg_gate_width),
        .cfg_gate_hold (cfg_gate_hold),
        .cfg_line_len  (cfg_line_len),
        .state         (state),
        .sub_cnt       (sub_cnt),
        .pix_idx       (pix_idx)
    );

    ccd_wave_gen #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_wave (
        .clk            (clk),
        .rst_n          (rst_n),
        .state          (state),
        .sub_cnt        (sub_cnt),
        .pix_idx        (pix_idx),
        .cfg_pix_period (cfg_pix_period),
        .cfg_rs_delay   (cfg_rs_delay),
        .cfg_rs_width   (cfg_rs_width),
        .cfg_sh_en      (cfg_sh_en),
        .cfg_sh_delay   (cfg_sh_delay),
        .cfg_sh_width   (cfg_sh_width),
        .cfg_valid_delay(cfg_valid_delay),
        .xfer_p1        (xfer_p1),
        .xfer_p2        (xfer_p2),
        .read_gate      (read_gate),
        .pix_reset      (pix_reset),
        .samp_hold      (samp_hold),
        .pix_valid      (pix_valid),
        .line_start     (line_start)
    );
endmodule

// File: rtl/ccd_clock_seq_chk.sv
// Port-level protocol checker for ccd_clock_seq, attached by bind.
// Assumes configuration is changed only while the sequencer is idle.
module ccd_clock_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_sh_en,
    input logic cfg_err,
    input logic xfer_p1,
    input logic xfer_p2,
    input logic read_gate,
    input logic pix_reset,
    input logic samp_hold,
    input logic pix_valid,
    input logic line_start
);
    // Transfer phases never overlap nor both drop.
    assert_phase_complement_R1: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_p1 != xfer_p2);

    // Phase 1 stays high while the read gate is open.
    assert_gate_phase_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        read_gate |-> xfer_p1);

    // No pixel activity while the read gate is open.
    assert_gate_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        read_gate |-> !(pix_reset || samp_hold || pix_valid || line_start));

    // Phase 1 was already high when the gate rose.
    assert_gate_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_gate) |-> $past(xfer_p1));

    // Phase 1 still high the cycle after the gate falls.
    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(read_gate) |-> xfer_p1);

    // Sample-and-hold silent when disabled.
    assert_sh_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_sh_en) |-> !samp_hold);

    // Reset and sample-and-hold pulses never overlap under a valid setup.
    assert_pulses_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_err) |-> !(pix_reset && samp_hold));

    // Line mark coincides with the falling phase-1 edge.
    assert_line_mark_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> $fell(xfer_p1));
endmodule

bind ccd_clock_seq ccd_clock_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_sh_en (cfg_sh_en),
    .cfg_err   (cfg_err),
    .xfer_p1   (xfer_p1),
    .xfer_p2   (xfer_p2),
    .read_gate (read_gate),
    .pix_reset (pix_reset),
    .samp_hold (samp_hold),
    .pix_valid (pix_valid),
    .line_start(line_start)
);

// File: tb/tb_ccd_clock_seq.sv
// Sweep bench for ccd_clock_seq with a reduced line-length floor.
module tb_ccd_clock_seq;
    localparam int CNT_W   = 8;
    localparam int LINE_W  = 12;
    localparam int MIN_PIX = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic free_run = 1'b0;
    logic [CNT_W-1:0] pix_period = 8'd4, rs_delay = 8'd0, rs_width = 8'd1;
    logic sh_en = 1'b0;
    logic [CNT_W-1:0] sh_delay = 8'd1, sh_width = 8'd1, valid_delay = 8'd0;
    logic [CNT_W-1:0] gate_setup = 8'd1, gate_width = 8'd1, gate_hold = 8'd1;
    logic [LINE_W-1:0] line_len = 12'd12;
    logic p1, p2, rg, prst, sh, pv, ls, err;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    ccd_clock_seq #(.CNT_W(CNT_W), .LINE_W(LINE_W), .MIN_LINE_PIX(MIN_PIX)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .free_run(free_run),
        .cfg_pix_period(pix_period), .cfg_rs_delay(rs_delay), .cfg_rs_width(rs_width),
        .cfg_sh_en(sh_en), .cfg_sh_delay(sh_delay), .cfg_sh_width(sh_width),
        .cfg_valid_delay(valid_delay), .cfg_gate_setup(gate_setup),
        .cfg_gate_width(gate_width), .cfg_gate_hold(gate_hold), .cfg_line_len(line_len),
        .xfer_p1(p1), .xfer_p2(p2), .read_gate(rg), .pix_reset(prst),
        .samp_hold(sh), .pix_valid(pv), .line_start(ls), .cfg_err(err)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected {p1,p2,gate,reset,sh,valid,mark} at cycle t after the first gate.
    function automatic logic [6:0] expect_at(input int t, input int nl);
        int s_, w_, h_, n_, p_, ll, ln, r, q, k, sb;
        logic e1, eg, er, es, ev, el;
        s_ = int'(gate_setup); w_ = int'(gate_width); h_ = int'(gate_hold);
        p_ = int'(pix_period);
        n_ = (int'(line_len) < MIN_PIX) ? MIN_PIX : int'(line_len);
        ll = s_ + w_ + h_ + n_ * p_;
        ln = t / ll; r = t % ll;
        e1 = 1'b1; eg = 1'b0; er = 1'b0; es = 1'b0; ev = 1'b0; el = 1'b0;
        if (ln < nl) begin
            if (r < w_) eg = 1'b1;
            else if (r >= w_ + h_ && r < w_ + h_ + n_ * p_) begin
                q = r - w_ - h_; k = q / p_; sb = q % p_;
                e1 = (sb >= p_ / 2);
                er = (sb >= int'(rs_delay)) && (sb < int'(rs_delay) + int'(rs_width));
                es = sh_en && (sb >= int'(sh_delay)) && (sb < int'(sh_delay) + int'(sh_width));
                ev = (sb == int'(rs_delay) + int'(rs_width) + int'(valid_delay));
                el = (k == 0) && (sb == 0);
            end
        end
        return {e1, !e1, eg, er, es, ev, el};
    endfunction

    // Run one or two lines and compare every output every cycle.
    task automatic run_lines(input logic fr);
        int nl, ll, n_, wait_c, second, n_pv, n_ls;
        logic [6:0] e, a;
        logic prev_rg;
        nl = fr ? 2 : 1;
        n_ = (int'(line_len) < MIN_PIX) ? MIN_PIX : int'(line_len);
        ll = int'(gate_setup) + int'(gate_width) + int'(gate_hold) + n_ * int'(pix_period);
        @(negedge clk);
        check(err == 1'b0, "R9 valid config flag", int'(err), 0);
        if (fr) free_run = 1'b1; else start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_c = 0;
        while (!rg && wait_c < 2000) begin @(negedge clk); wait_c++; end
        check(rg == 1'b1, "R10 line begins", int'(rg), 1);
        second = -1; n_pv = 0; n_ls = 0; prev_rg = 1'b0;
        for (int t = 0; t < nl * ll + int'(pix_period) + 6; t++) begin
            a = {p1, p2, rg, prst, sh, pv, ls};
            e = expect_at(t, nl);
            check(a[6:5] == e[6:5], "R1 transfer phases", int'(a[6:5]), int'(e[6:5]));
            check(a[4] == e[4], "R2 read gate", int'(a[4]), int'(e[4]));
            check(a[3] == e[3], "R5 pixel reset", int'(a[3]), int'(e[3]));
            check(a[2] == e[2], "R6 sample-hold", int'(a[2]), int'(e[2]));
            check(a[1] == e[1], "R7 valid strobe", int'(a[1]), int'(e[1]));
            check(a[0] == e[0], "R8 line mark", int'(a[0]), int'(e[0]));
            if (t > 0 && rg && !prev_rg && second < 0) second = t;
            n_pv += int'(pv); n_ls += int'(ls);
            prev_rg = rg;
            if (fr && t == ll + 1) free_run = 1'b0;
            if (!fr && t == int'(gate_width) + int'(gate_hold) + 2) start = 1'b1;
            if (!fr && t == int'(gate_width) + int'(gate_hold) + 3) start = 1'b0;
            @(negedge clk);
        end
        check(second == (fr ? ll : -1), "R3 R10 next gate timing", second, fr ? ll : -1);
        check(n_pv == nl * n_, "R4 pixels per line", n_pv, nl * n_);
        check(n_ls == nl, "R8 line marks", n_ls, nl);
    endtask

    // Bad configuration must flag and block any line.
    task automatic expect_blocked(input string what);
        int gates;
        @(negedge clk);
        check(err == 1'b1, what, int'(err), 1);
        start = 1'b1; free_run = 1'b1;
        gates = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            start = 1'b0;
            gates += int'(rg) + int'(!p1);
        end
        free_run = 1'b0;
        check(gates == 0, "R9 no line while flagged", gates, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check({p1, p2, rg, prst, sh, pv, ls} == 7'b1000000, "R11 reset outputs",
              int'({p1, p2, rg, prst, sh, pv, ls}), 7'b1000000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check({p1, p2, rg, prst, sh, pv, ls} == 7'b1000000, "R11 idle outputs",
              int'({p1, p2, rg, prst, sh, pv, ls}), 7'b1000000);

        // Sweep: periods, reset offsets, sample-hold on/off, both modes.
        for (int p = 4; p <= 9; p++) begin
            for (int rd = 0; rd <= 1; rd++) begin
                for (int se = 0; se <= 1; se++) begin
                    for (int fr = 0; fr <= 1; fr++) begin
                        pix_period  = 8'(p);
                        rs_delay    = 8'(rd);
                        rs_width    = 8'(1 + int'(p > 5));
                        sh_en       = 1'(se);
                        sh_delay    = 8'(rd + 1 + int'(p > 5));
                        sh_width    = 8'(p - (rd + 1 + int'(p > 5)) - (p % 2));
                        valid_delay = fr ? 8'(p - 1 - rd - (1 + int'(p > 5))) : 8'd0;
                        gate_setup  = 8'(1 + rd);
                        gate_width  = 8'(1 + p % 3);
                        gate_hold   = 8'(1 + se);
                        line_len    = (p % 2 == 1) ? 12'd3 : 12'd14;   // R4 floor
                        run_lines(1'(fr));
                    end
                end
            end
        end

        // R9: misfit configurations
        pix_period = 8'd6; rs_delay = 8'd1; rs_width = 8'd2; sh_en = 1'b1;
        sh_delay = 8'd3; sh_width = 8'd2; valid_delay = 8'd1;
        gate_setup = 8'd2; gate_width = 8'd2; gate_hold = 8'd2; line_len = 12'd12;
        valid_delay = 8'd3;  expect_blocked("R9 valid beyond period");
        valid_delay = 8'd1; sh_delay = 8'd2; expect_blocked("R9 sample-hold overlaps reset");
        sh_delay = 8'd3; sh_width = 8'd4; expect_blocked("R9 sample-hold beyond period");
        sh_width = 8'd2; rs_width = 8'd0; expect_blocked("R9 zero reset width");
        rs_width = 8'd2; gate_hold = 8'd0; expect_blocked("R9 zero gate hold");
        gate_hold = 8'd2; pix_period = 8'd1; rs_delay = 8'd0; rs_width = 8'd1;
        valid_delay = 8'd0; sh_en = 1'b0; expect_blocked("R9 period below two");
        // R9: disabled sample-hold fields are not checked; line runs normally.
        pix_period = 8'd6; rs_delay = 8'd1; rs_width = 8'd2; valid_delay = 8'd1;
        sh_en = 1'b0; sh_delay = 8'd0; sh_width = 8'd0;
        run_lines(1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule